// File: doc/BRIEF.md
# Supervisory Reset Pulse Controller

This block sequences the board reset line of a processor companion. It takes a synchronous "supply below threshold" flag from an external comparator and the synchronised level of a bidirectional, active-low reset pin. From these it produces an open-drain enable that pulls that pin low, and a write-inhibit flag for an attached non-volatile memory. It covers four jobs: holding reset through power-up, rejecting short supply dips, stretching a short manual press into a full reset pulse, and keeping the memory locked while any reset is in force.

The timeout and the glitch-reject window are parameters counted in system clock cycles. The reset pin is treated as wired-AND. A low level driven from outside, seen while the block is idle, is a manual reset request. Only its falling edge starts the timer. Because the line stays low as long as anyone pulls it, the line low time is the longer of the timeout and the external pulse. The block's own drive is masked so that it never looks like an external press.

Top module: `supply_reset_sequencer`

## Requirements
- R1: While the qualified supply-low condition persists, `pull_low_o` stays high without a break, whatever the counter state was when the condition arrived.
- R2: After `supply_low_i` is first sampled low following a qualified supply-low event, `pull_low_o` falls at the (TIMEOUT_CYC+2)-th rising edge.
- R3: `supply_low_i` high for fewer than GLITCH_CYC consecutive rising edges has no effect on either output. High for GLITCH_CYC or more edges makes `pull_low_o` rise at edge GLITCH_CYC+1, counted from the first edge that samples it high.
- R4: When idle, a low level on `pin_level_i` (0 = line low) sampled at one rising edge makes `pull_low_o` rise at the third edge. It stays high for exactly TIMEOUT_CYC cycles, whether the pin is held low for one cycle or much longer.
- R5: `wr_inhibit_o` is high whenever `pull_low_o` is high, and also while the synchronised pin level is low. It falls two edges after the line returns high.
- R6: The falling line level caused by the block's own drive is never taken as a manual press. A supply-low event of exactly GLITCH_CYC cycles yields one pulse of TIMEOUT_CYC+1 cycles.
- R7: A qualified supply-low event during a running timeout restarts the timeout from zero once the supply recovers. A sub-window dip during a timeout neither shortens nor extends it.
- R8: `rst_n` low forces `pull_low_o` and `wr_inhibit_o` high at once. After release, `pull_low_o` stays high for TIMEOUT_CYC-1 further samples and falls at edge TIMEOUT_CYC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| supply_low_i | input | 1 | Synchronous flag from the supply comparator, 1 = supply below threshold |
| pin_level_i | input | 1 | Raw level of the wired-AND reset line, 0 = line low |
| pull_low_o | output | 1 | Open-drain enable, 1 = pull the reset line low |
| wr_inhibit_o | output | 1 | 1 = writes to the attached memory are blocked |

## Verification
Supply dips are placed either side of the glitch window, one cycle short and exactly at the window. A filter off by one either fires on the short dip or misses the real one. A brownout of exactly the window length is followed until release. A design that took its own drive for an external press would restart the timer three cycles into the pulse and release late. Manual presses of one cycle, a few cycles and longer than the timeout must all give the same pulse length, and the write inhibit must follow the held line until two cycles after release. A dip during a timeout must restart the count only when it clears the window, so a design that reset the counter on any raw dip shows up as a longer pulse.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

  // Sequencer states: line released, held by supply, timing out
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_HOLD = 2'd1,
    SEQ_TIME = 2'd2
  } seq_state_e;

endpackage

// File: rtl/rsv_sync.sv
module rsv_sync #(
  parameter int  STAGES  = 2,
  parameter bit  RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb stage_d = d_i;
    end else begin : g_chain
      always_comb stage_d = {stage_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= {STAGES{RST_VAL}};
    else        stage_q <= stage_d;
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/rsv_glitch_filter.sv
module rsv_glitch_filter #(
  parameter int GLITCH_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_low_i,
  output logic brown_o
);

  localparam int GW = (GLITCH_CYC < 2) ? 1 : $clog2(GLITCH_CYC);
  localparam logic [GW-1:0] RUN_LAST = GW'(GLITCH_CYC - 1);

  logic [GW-1:0] run_q, run_d;
  logic          run_en;
  logic          brown_q, brown_d;

  // Count consecutive low-supply samples, saturating at the window end
  always_comb begin
    run_en = 1'b1;
    if (!supply_low_i)          run_d = '0;
    else if (run_q == RUN_LAST) begin
      run_d  = run_q;
      run_en = 1'b0;
    end else                    run_d = run_q + GW'(1);
    brown_d = supply_low_i & (brown_q | (run_q == RUN_LAST));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      brown_q <= 1'b0;
    end else begin
      if (run_en) run_q <= run_d;
      brown_q <= brown_d;
    end
  end

  assign brown_o = brown_q;

  AST_BROWN_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brown_q) |-> $past(supply_low_i));  // R3
  AST_BROWN_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_low_i |=> !brown_q);  // R3

endmodule

// File: rtl/rsv_edge_qual.sv
module rsv_edge_qual #(
  parameter int MASK_DEPTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_sync_i,
  input  logic drive_i,
  output logic ext_fall_o
);

  logic                  prev_q;
  logic [MASK_DEPTH-1:0] hist_q, hist_d;
  logic                  own_recent;

  // Record recent own drive so that self-caused falls are discarded
  generate
    if (MASK_DEPTH == 1) begin : g_hist1
      always_comb hist_d = drive_i;
    end else begin : g_histn
      always_comb hist_d = {hist_q[MASK_DEPTH-2:0], drive_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      hist_q <= '1;
    end else begin
      prev_q <= pin_sync_i;
      hist_q <= hist_d;
    end
  end

  assign own_recent = |hist_q;
  assign ext_fall_o = prev_q & ~pin_sync_i & ~own_recent & ~drive_i;

  AST_FALL_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ext_fall_o |-> ($past(drive_i) == 1'b0));  // R6

endmodule

// File: rtl/rsv_hold_timer.sv
module rsv_hold_timer
  import rsv_pkg::*;
#(
  parameter int TIMEOUT_CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic brown_i,
  input  logic ext_fall_i,
  output logic drive_o
);

  localparam int TW = (TIMEOUT_CYC < 2) ? 1 : $clog2(TIMEOUT_CYC);
  localparam logic [TW-1:0] CNT_LAST = TW'(TIMEOUT_CYC - 1);

  seq_state_e    state_q, state_d;
  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (brown_i) begin
          state_d = SEQ_HOLD;
        end else if (ext_fall_i) begin
          state_d = SEQ_TIME;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end
      end
      SEQ_HOLD: begin
        cnt_d  = '0;
        cnt_en = 1'b1;
        if (!brown_i) state_d = SEQ_TIME;
      end
      SEQ_TIME: begin
        cnt_en = 1'b1;
        if (brown_i) begin
          state_d = SEQ_HOLD;
          cnt_d   = '0;
        end else if (ext_fall_i) begin
          cnt_d = '0;
        end else if (cnt_q == CNT_LAST) begin
          state_d = SEQ_IDLE;
          cnt_en  = 1'b0;
        end else begin
          cnt_d = cnt_q + TW'(1);
        end
      end
      default: begin
        state_d = SEQ_HOLD;
        cnt_d   = '0;
        cnt_en  = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_TIME;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign drive_o = (state_q != SEQ_IDLE);

  AST_HOLD_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    brown_i |=> drive_o);  // R1
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST);  // R2
  AST_FULL_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drive_o) |-> ($past(cnt_q) == CNT_LAST));  // R2

endmodule

// File: rtl/supply_reset_sequencer.sv
module supply_reset_sequencer #(
  parameter int TIMEOUT_CYC = 40,
  parameter int GLITCH_CYC  = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_low_i,
  input  logic pin_level_i,
  output logic pull_low_o,
  output logic wr_inhibit_o
);

  localparam int MASK_DEPTH = SYNC_STAGES + 1;

  logic pin_sync;
  logic brown;
  logic ext_fall;
  logic drive;

  rsv_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pin_level_i),
    .q_o   (pin_sync)
  );

  rsv_glitch_filter #(
    .GLITCH_CYC (GLITCH_CYC)
  ) u_filter (
    .clk          (clk),
    .rst_n        (rst_n),
    .supply_low_i (supply_low_i),
    .brown_o      (brown)
  );

  rsv_edge_qual #(
    .MASK_DEPTH (MASK_DEPTH)
  ) u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_sync_i (pin_sync),
    .drive_i    (drive),
    .ext_fall_o (ext_fall)
  );

  rsv_hold_timer #(
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .brown_i    (brown),
    .ext_fall_i (ext_fall),
    .drive_o    (drive)
  );

  assign pull_low_o   = drive | ~rst_n;
  assign wr_inhibit_o = drive | ~rst_n | ~pin_sync;

  AST_INHIBIT_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    pull_low_o |-> wr_inhibit_o);  // R5
  AST_INHIBIT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_sync |-> wr_inhibit_o);  // R5

endmodule

// File: tb/supply_reset_sequencer_test.sv
`timescale 1ns/1ps
module supply_reset_sequencer_test;

  localparam int T  = 40;
  localparam int G  = 6;
  localparam int W  = 120;
  localparam int NV = 9;

  // es, el, ss, sl, exp_first, exp_len, exp_last_wi (-1 skip), tag
  localparam int VEC [NV][8] = '{
    '{0, 0,     0,  G-1,  0,   0,         -1,     3},
    '{0, 0,     0,  1,    0,   0,         -1,     3},
    '{0, 0,     0,  G,    G+1, T+1,       -1,     6},
    '{0, 0,     0,  G+10, G+1, T+11,      -1,     2},
    '{0, 1,     0,  0,    3,   T,         -1,     4},
    '{0, 5,     0,  0,    3,   T,         -1,     4},
    '{0, T+20,  0,  0,    3,   T,         T+21,   5},
    '{0, 2,     10, G-1,  3,   T,         -1,     7},
    '{0, 2,     10, G+2,  3,   G+T+11,    -1,     7}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic supply_low;
  logic ext_low;
  logic pull_low;
  logic wr_inhibit;
  wire  pin_line = ~(ext_low | pull_low);

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #2.5 clk = ~clk;

  supply_reset_sequencer #(
    .TIMEOUT_CYC (T),
    .GLITCH_CYC  (G),
    .SYNC_STAGES (2)
  ) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .supply_low_i (supply_low),
    .pin_level_i  (pin_line),
    .pull_low_o   (pull_low),
    .wr_inhibit_o (wr_inhibit)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad   = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic string tag_name(input int n);
    case (n)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Caller stands on a negedge. k=0 drives only; k>=1 samples then drives.
  task automatic run_case(input int es, input int el, input int ss, input int sl,
                          input int w, output int first, output int len,
                          output int last_wi, output int viol);
    bit ended;
    first = 0; len = 0; last_wi = 0; viol = 0; ended = 1'b0;
    for (int k = 0; k <= w; k++) begin
      if (k >= 1) begin
        @(negedge clk);
        if (pull_low) begin
          if (first == 0) begin first = k; len = 1; end
          else if (!ended) len = len + 1;
        end else if (first != 0) begin
          ended = 1'b1;
        end
        if (wr_inhibit) last_wi = k;
        if (pull_low && !wr_inhibit) viol = viol + 1;
      end
      ext_low    = (el > 0) && (k >= es) && (k < es + el);
      supply_low = (sl > 0) && (k >= ss) && (k < ss + sl);
    end
    ext_low    = 1'b0;
    supply_low = 1'b0;
  endtask

  task automatic settle();
    while (pull_low) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    int f, l, lw, v, vsum;
    vsum       = 0;
    rst_n      = 1'b0;
    supply_low = 1'b0;
    ext_low    = 1'b0;
    repeat (4) @(negedge clk);
    check(pull_low == 1'b1, "R8", "pull_low during reset", int'(pull_low), 1);
    check(wr_inhibit == 1'b1, "R8", "wr_inhibit during reset", int'(wr_inhibit), 1);

    // Power-on timeout
    rst_n = 1'b1;
    run_case(0, 0, 0, 0, W, f, l, lw, v);
    vsum += v;
    check(f == 1, "R8", "power-on first high sample", f, 1);
    check(l == T-1, "R8", "power-on pulse length", l, T-1);
    settle();

    // Table of vectors
    for (int i = 0; i < NV; i++) begin
      run_case(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], W, f, l, lw, v);
      vsum += v;
      check(f == VEC[i][4], tag_name(VEC[i][7]), $sformatf("vec%0d first", i), f, VEC[i][4]);
      check(l == VEC[i][5], tag_name(VEC[i][7]), $sformatf("vec%0d length", i), l, VEC[i][5]);
      if (VEC[i][6] >= 0)
        check(lw == VEC[i][6], tag_name(VEC[i][7]), $sformatf("vec%0d last inhibit", i), lw, VEC[i][6]);
      settle();
    end

    // Asynchronous reset while idle takes effect at once (R8)
    #1 rst_n = 1'b0;
    #0.5;
    check(pull_low == 1'b1, "R8", "async pull_low", int'(pull_low), 1);
    check(wr_inhibit == 1'b1, "R8", "async wr_inhibit", int'(wr_inhibit), 1);
    @(negedge clk);
    supply_low = 1'b1;
    repeat (3) @(negedge clk);

    // Power-up with supply low for 50 cycles (R1)
    rst_n = 1'b1;
    run_case(0, 0, 0, 50, W, f, l, lw, v);
    vsum += v;
    check(f == 1, "R1", "low-supply power-up first", f, 1);
    check(l == 51 + T, "R1", "low-supply power-up length", l, 51 + T);
    settle();

    check(vsum == 0, "R5", "samples with pull_low but no inhibit", vsum, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule